// File: doc/BRIEF.md
# Display Register-Batch Command Executor

This block runs a list of register-programming commands that software has placed in memory ahead of time. After a start pulse it reads 32-bit words from a word-addressed memory. It begins at a head word index and stops when the read pointer reaches a tail word index. Every command is a pair of words that starts on an even word index. The second word of the pair carries the opcode in bits [31:24].

The block only writes registers; it never reads them. It performs single register writes with per-byte lane enables. It also performs burst writes, where a count word sets how many following data words all go to one register offset. Delay commands (microseconds, vblanks, inside or outside a line window) are handed to an external wait unit, and the executor stalls until that unit reports completion. An interrupt command raises a program-done flag. An opcode the block cannot run raises an error flag and ends the run.

Top module: `regbatch_exec`

## Requirements
- R1: During and right after reset, `busy`, `err`, `irq`, `wr_valid`, `wait_valid` and `mem_rd` are all low.
- R2: A `start` pulse while idle loads `head_idx`/`tail_idx`, and `busy` is high in the following cycle. When head equals tail, the run ends with no register write and no wait request.
- R3: Opcode 0x01 issues one register write. `wr_data` is the first word, `wr_addr` is bits [19:0] of the second word, and `wr_be` is bits [23:20] of the second word (bit 3 enables data bits [31:24]).
- R4: While `wr_valid` is high and `wr_ready` is low, the write fields stay unchanged and no memory read is issued.
- R5: Opcode 0x09 uses the first word as a count N. The next N memory words are written, in order, to the offset in bits [19:0] of the second word, with `wr_be` = 4'hF. When N = 0, no write is made.
- R6: When N is odd, the one word after the burst data is skipped, and the next command is decoded from the even word that follows it.
- R7: Opcodes 0x02, 0x04, 0x05 and 0x06 raise `wait_valid` with `wait_code` = opcode[2:0], `wait_lo` = first word and `wait_hi` = second word bits [23:0]. These hold until `wait_done`. Nothing is read or written meanwhile.
- R8: Opcode 0x07 sets `irq`. It stays set until the next accepted `start`.
- R9: Opcode 0x00 has no effect, so a zero-filled area before the tail runs as no-ops.
- R10: Opcodes 0x03, 0x08 and 0x0A–0xFF set `err` and drop `busy` at the same edge. No later command of that run is executed. `err` clears on the next accepted `start`.
- R11: `busy` stays high until the pointer has reached the tail and the last write has been accepted. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| head_idx | input | AW | First word index of the queue |
| tail_idx | input | AW | Word index one past the queue end |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word index |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Register write data |
| wr_be | output | 4 | Byte lane enables |
| wait_valid | output | 1 | Wait request to the wait unit |
| wait_done | input | 1 | Wait unit has finished |
| wait_code | output | 3 | Wait kind (opcode low bits) |
| wait_lo | output | 32 | First command word for the wait |
| wait_hi | output | 24 | Second command word bits [23:0] |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Program interrupt flag |
| err | output | 1 | Unknown-opcode error flag |

## Verification
The hardest case to reach is a burst with an odd count, where the pad word must be skipped and command alignment kept. In the same run, the write port stalls on some of the burst data words. The stimulus puts a nonzero junk value in the pad word, so a missed skip decodes as a misaligned command and shows up as a wrong write. A stall pattern on `wr_ready` holds several burst words for more than one cycle. A second start pulse is sent in the middle of a run full of waits, to confirm that the restart is ignored.

// File: rtl/regbatch_pkg.sv
package regbatch_pkg;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [7:0] OP_WRITE  = 8'h01;
    localparam logic [7:0] OP_WUSEC  = 8'h02;
    localparam logic [7:0] OP_WVBL   = 8'h04;
    localparam logic [7:0] OP_WIN    = 8'h05;
    localparam logic [7:0] OP_WOUT   = 8'h06;
    localparam logic [7:0] OP_IRQ    = 8'h07;
    localparam logic [7:0] OP_BURST  = 8'h09;

    typedef enum logic [2:0] {
        K_NOP,
        K_WRITE,
        K_WAIT,
        K_IRQ,
        K_BURST,
        K_BAD
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0,
        S_LD0,
        S_LD1,
        S_EXEC,
        S_WR,
        S_WAIT,
        S_BRD,
        S_BLD,
        S_BWR
    } state_e;

    typedef struct packed {
        state_e      state;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] cnt;
        logic [31:0] data;
        logic        irq;
        logic        err;
    } st_t;

endpackage

// File: rtl/regbatch_decode.sv
module regbatch_decode
    import regbatch_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind
);
    always_comb begin
        case (opcode)
            OP_NOP:   kind = K_NOP;
            OP_WRITE: kind = K_WRITE;
            OP_WUSEC,
            OP_WVBL,
            OP_WIN,
            OP_WOUT:  kind = K_WAIT;
            OP_IRQ:   kind = K_IRQ;
            OP_BURST: kind = K_BURST;
            default:  kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/regbatch_fetch_ptr.sv
module regbatch_fetch_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] tail,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          at_end
);
    logic [AW-1:0] ptr_d, ptr_q;
    logic [AW-1:0] tail_d, tail_q;

    always_comb begin
        ptr_d  = ptr_q;
        tail_d = tail_q;
        if (load) begin
            ptr_d  = head;
            tail_d = tail;
        end else if (step) begin
            ptr_d = ptr_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            tail_q <= '0;
        end else begin
            ptr_q  <= ptr_d;
            tail_q <= tail_d;
        end
    end

    assign ptr    = ptr_q;
    assign at_end = (ptr_q >= tail_q);
endmodule

// File: rtl/regbatch_exec.sv
module regbatch_exec
    import regbatch_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head_idx,
    input  logic [AW-1:0] tail_idx,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [19:0]   wr_addr,
    output logic [31:0]   wr_data,
    output logic [3:0]    wr_be,
    output logic          wait_valid,
    input  logic          wait_done,
    output logic [2:0]    wait_code,
    output logic [31:0]   wait_lo,
    output logic [23:0]   wait_hi,
    output logic          busy,
    output logic          irq,
    output logic          err
);
    localparam logic [3:0] BE_ALL = 4'hF;

    st_t   st_d, st_q;
    kind_e kind;
    logic  ptr_load, ptr_step, at_end;
    logic [AW-1:0] ptr;

    regbatch_decode u_dec (
        .opcode (st_q.w1[31:24]),
        .kind   (kind)
    );

    regbatch_fetch_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ptr_load),
        .head   (head_idx),
        .tail   (tail_idx),
        .step   (ptr_step),
        .ptr    (ptr),
        .at_end (at_end)
    );

    always_comb begin
        st_d       = st_q;
        ptr_load   = 1'b0;
        ptr_step   = 1'b0;
        mem_rd     = 1'b0;
        wr_valid   = 1'b0;
        wait_valid = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (start) begin
                    ptr_load   = 1'b1;
                    st_d.irq   = 1'b0;
                    st_d.err   = 1'b0;
                    st_d.state = S_RD0;
                end
            end
            S_RD0: begin
                if (at_end) begin
                    st_d.state = S_IDLE;
                end else begin
                    mem_rd     = 1'b1;
                    ptr_step   = 1'b1;
                    st_d.state = S_LD0;
                end
            end
            S_LD0: begin
                st_d.w0    = mem_rdata;
                mem_rd     = 1'b1;
                ptr_step   = 1'b1;
                st_d.state = S_LD1;
            end
            S_LD1: begin
                st_d.w1    = mem_rdata;
                st_d.state = S_EXEC;
            end
            S_EXEC: begin
                case (kind)
                    K_NOP:   st_d.state = S_RD0;
                    K_WRITE: st_d.state = S_WR;
                    K_WAIT:  st_d.state = S_WAIT;
                    K_IRQ: begin
                        st_d.irq   = 1'b1;
                        st_d.state = S_RD0;
                    end
                    K_BURST: begin
                        st_d.cnt   = st_q.w0;
                        st_d.state = (st_q.w0 == 32'd0) ? S_RD0 : S_BRD;
                    end
                    default: begin
                        st_d.err   = 1'b1;
                        st_d.state = S_IDLE;
                    end
                endcase
            end
            S_WR: begin
                wr_valid = 1'b1;
                if (wr_ready) st_d.state = S_RD0;
            end
            S_WAIT: begin
                wait_valid = 1'b1;
                if (wait_done) st_d.state = S_RD0;
            end
            S_BRD: begin
                mem_rd     = 1'b1;
                ptr_step   = 1'b1;
                st_d.state = S_BLD;
            end
            S_BLD: begin
                st_d.data  = mem_rdata;
                st_d.state = S_BWR;
            end
            S_BWR: begin
                wr_valid = 1'b1;
                if (wr_ready) begin
                    st_d.cnt = st_q.cnt - 32'd1;
                    if (st_q.cnt == 32'd1) begin
                        // odd count leaves the pointer on the pad word
                        ptr_step   = ptr[0];
                        st_d.state = S_RD0;
                    end else begin
                        st_d.state = S_BRD;
                    end
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: S_IDLE, w0: '0, w1: '0, cnt: '0,
                      data: '0, irq: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = ptr;
    assign wr_addr   = st_q.w1[19:0];
    assign wr_data   = (st_q.state == S_BWR) ? st_q.data : st_q.w0;
    assign wr_be     = (st_q.state == S_BWR) ? BE_ALL : st_q.w1[23:20];
    assign wait_code = st_q.w1[26:24];
    assign wait_lo   = st_q.w0;
    assign wait_hi   = st_q.w1[23:0];
    assign busy      = (st_q.state != S_IDLE);
    assign irq       = st_q.irq;
    assign err       = st_q.err;
endmodule

// File: rtl/regbatch_exec_chk.sv
module regbatch_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        irq,
    input logic        err,
    input logic        mem_rd,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [19:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be,
    input logic        wait_valid,
    input logic        wait_done,
    input logic [2:0]  wait_code
);
    p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)
                                     && $stable(wr_data) && $stable(wr_be)));

    p_no_read_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !mem_rd);

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && !wait_done) |=> (wait_valid && $stable(wait_code)));

    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_valid |-> (!mem_rd && !wr_valid));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(start && !busy)) |=> irq);

    p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !wait_valid && !mem_rd));

    p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, wr_valid, wait_valid}));
endmodule

bind regbatch_exec regbatch_exec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .irq        (irq),
    .err        (err),
    .mem_rd     (mem_rd),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .wait_valid (wait_valid),
    .wait_done  (wait_done),
    .wait_code  (wait_code)
);

// File: tb/regbatch_exec_tb_top.sv
module regbatch_exec_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] head_idx = '0;
    logic [AW-1:0] tail_idx = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [19:0]   wr_addr;
    logic [31:0]   wr_data;
    logic [3:0]    wr_be;
    logic          wait_valid;
    logic          wait_done = 1'b0;
    logic [2:0]    wait_code;
    logic [31:0]   wait_lo;
    logic [23:0]   wait_hi;
    logic          busy, irq, err;

    regbatch_exec #(.AW(AW)) dut_i (.*);

    always #10 clk = ~clk;

    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit stall_mode = 1'b0;
    int wcnt = 0;
    int wlat = 4;

    logic [55:0] exp_wr[$];
    logic [58:0] exp_wt[$];
    bit exp_irq, exp_err;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: walk the queue image and list the expected events
    task automatic build_expect(input int h, input int t);
        int a;
        logic [31:0] w0, w1;
        exp_wr.delete();
        exp_wt.delete();
        exp_irq = 1'b0;
        exp_err = 1'b0;
        a = h;
        while (a < t && !exp_err) begin
            w0 = mem[a];
            w1 = mem[a+1];
            a += 2;
            case (w1[31:24])
                8'h00: ;
                8'h01: exp_wr.push_back({w1[19:0], w1[23:20], w0});
                8'h02, 8'h04, 8'h05, 8'h06:
                    exp_wt.push_back({w1[26:24], w0, w1[23:0]});
                8'h07: exp_irq = 1'b1;
                8'h09: begin
                    for (int i = 0; i < int'(w0); i++)
                        exp_wr.push_back({w1[19:0], 4'hF, mem[a+i]});
                    a += int'(w0);
                    if (a % 2 == 1) a++;
                end
                default: exp_err = 1'b1;
            endcase
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        wr_ready = stall_mode ? (cyc % 3 == 2) : 1'b1;
        if (wait_done) begin
            wait_done = 1'b0;
            wcnt = 0;
        end else if (wait_valid) begin
            if (wcnt == wlat) wait_done = 1'b1;
            else wcnt++;
        end
    end

    bit          prev_stall = 1'b0;
    logic [55:0] prev_wr;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_stall)
                chk(wr_valid && {wr_addr, wr_be, wr_data} == prev_wr, "R4",
                    "stalled write changed", {7'd0, wr_valid, wr_addr, wr_be, wr_data},
                    {8'd1, prev_wr});
            if (wr_valid)
                chk(!mem_rd, "R4", "read during write", 64'(mem_rd), 64'd0);
            if (wait_valid)
                chk(!mem_rd && !wr_valid, "R7", "activity during wait",
                    {62'd0, mem_rd, wr_valid}, 64'd0);
            if (wr_valid && wr_ready) begin
                if (exp_wr.size() == 0)
                    chk(1'b0, "R3", "unexpected write", {8'd0, wr_addr, wr_be, wr_data}, 64'd0);
                else begin
                    logic [55:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_addr, wr_be, wr_data} == e, "R3 R5 R6", "write fields",
                        {8'd0, wr_addr, wr_be, wr_data}, {8'd0, e});
                end
            end
            if (wait_valid && wait_done) begin
                if (exp_wt.size() == 0)
                    chk(1'b0, "R7", "unexpected wait", {5'd0, wait_code, wait_lo, wait_hi}, 64'd0);
                else begin
                    logic [58:0] e;
                    e = exp_wt.pop_front();
                    chk({wait_code, wait_lo, wait_hi} == e, "R7", "wait fields",
                        {5'd0, wait_code, wait_lo, wait_hi}, {5'd0, e});
                end
            end
            prev_stall = wr_valid && !wr_ready;
            prev_wr    = {wr_addr, wr_be, wr_data};
        end
    end

    task automatic run(input int h, input int t, input bit stall, input bit poke,
                       input string tag);
        int guard;
        stall_mode = stall;
        build_expect(h, t);
        @(negedge clk);
        head_idx = AW'(h);
        tail_idx = AW'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #2;
        chk(busy == 1'b1, "R2", {tag, " busy after start"}, 64'(busy), 64'd1);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            #2;
            guard++;
        end
        chk(!busy, "R11", {tag, " run ends"}, 64'(busy), 64'd0);
        chk(exp_wr.size() == 0, "R11", {tag, " all writes accepted"},
            64'(exp_wr.size()), 64'd0);
        chk(exp_wt.size() == 0, "R7", {tag, " all waits issued"},
            64'(exp_wt.size()), 64'd0);
        chk(irq == exp_irq, "R8", {tag, " irq flag"}, 64'(irq), 64'(exp_irq));
        chk(err == exp_err, "R10", {tag, " err flag"}, 64'(err), 64'(exp_err));
    endtask

    function automatic logic [31:0] cmd(input logic [7:0] op, input logic [3:0] be,
                                        input logic [19:0] off);
        return {op, be, off};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        // queue A: words 0..31, writes, no-ops, bursts (odd with junk pad, even, zero)
        mem[0]  = 32'h1111_2222; mem[1]  = cmd(8'h01, 4'hF, 20'h00100);
        mem[2]  = 32'h5A5A_5A5A; mem[3]  = cmd(8'h00, 4'h0, 20'h00000);
        mem[4]  = 32'hA5A5_0F0F; mem[5]  = cmd(8'h01, 4'b0101, 20'h00204);
        mem[6]  = 32'd3;         mem[7]  = cmd(8'h09, 4'h0, 20'h00300);
        mem[8]  = 32'hAAAA_0001; mem[9]  = 32'hAAAA_0002; mem[10] = 32'hAAAA_0003;
        mem[11] = 32'hDEAD_BEEF;
        mem[12] = 32'd2;         mem[13] = cmd(8'h09, 4'h0, 20'h00304);
        mem[14] = 32'hBBBB_0001; mem[15] = 32'hBBBB_0002;
        mem[16] = 32'd0;         mem[17] = cmd(8'h09, 4'h0, 20'h00308);
        mem[18] = 32'h1234_5678; mem[19] = cmd(8'h01, 4'b1000, 20'hFFFFF);
        // queue B: words 32..47, waits and interrupt
        mem[32] = 32'd5;         mem[33] = cmd(8'h02, 4'h0, 20'h0);
        mem[34] = 32'd0;         mem[35] = cmd(8'h07, 4'h0, 20'h0);
        mem[36] = 32'd2;         mem[37] = cmd(8'h04, 4'h0, 20'h0);
        mem[38] = 32'h00AB_CDEF; mem[39] = {8'h05, 24'h000123};
        mem[40] = 32'h0000_0001; mem[41] = cmd(8'h01, 4'hF, 20'h00010);
        mem[42] = 32'd7;         mem[43] = {8'h06, 24'h000456};
        // queue C: words 48..63, bad opcode 3 after one write
        mem[48] = 32'h0000_CAFE; mem[49] = cmd(8'h01, 4'hF, 20'h00020);
        mem[50] = 32'd0;         mem[51] = cmd(8'h03, 4'h0, 20'h0);
        mem[52] = 32'h0000_BAD0; mem[53] = cmd(8'h01, 4'hF, 20'h00024);
        // queue D: words 64..79, interrupt then bad opcode 8
        mem[64] = 32'd0;         mem[65] = cmd(8'h07, 4'h0, 20'h0);
        mem[66] = 32'd0;         mem[67] = cmd(8'h08, 4'h0, 20'h0);
        mem[68] = 32'h0000_BAD1; mem[69] = cmd(8'h01, 4'hF, 20'h00028);
        // queue E: words 80..95, bad opcode 0xC8
        mem[80] = 32'd0;         mem[81] = cmd(8'hC8, 4'h0, 20'h0);

        repeat (3) @(negedge clk);
        #2;
        chk({busy, err, irq, wr_valid, wait_valid, mem_rd} == 6'd0, "R1", "in reset",
            {58'd0, busy, err, irq, wr_valid, wait_valid, mem_rd}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk({busy, err, irq, wr_valid, wait_valid, mem_rd} == 6'd0, "R1", "after reset",
            {58'd0, busy, err, irq, wr_valid, wait_valid, mem_rd}, 64'd0);

        run(0, 0, 1'b0, 1'b0, "R2 empty queue");
        run(0, 32, 1'b1, 1'b0, "R5 R6 R9 stalled");
        run(0, 32, 1'b0, 1'b0, "R3 R9 free");
        run(32, 48, 1'b0, 1'b1, "R7 R8 R11 with restart poke");
        run(48, 64, 1'b0, 1'b0, "R10 opcode 3");
        run(64, 80, 1'b1, 1'b0, "R10 opcode 8 after irq");
        run(80, 96, 1'b0, 1'b0, "R10 R8 clears on start");
        run(16, 16, 1'b0, 1'b0, "R2 R10 flags cleared");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule